// File: doc/BRIEF.md
# Line-Energy Sleep Controller

This block decides, every clock, whether the transceiver core is powered. There are two ways to put the core to sleep. The first is a forced sleep bit from the management register file, which holds the core down for as long as it is set. The second is an automatic mode. When that mode is enabled, the core sleeps whenever the line carries no energy and wakes when energy returns. The management logic and the energy detector sit outside the switched domain and stay alive throughout.

The controller drives a core power-down output and a transmit-inhibit output, so nothing reaches the line while the core is down. Whenever the core leaves sleep, for either cause, the controller emits a single-cycle exit pulse that the reset block uses to restart the core. When a wake is caused by returning line energy and the interrupt is enabled, it sets a sticky flag that pulls an active-low interrupt line. A management read strobe clears the flag. The energy indicator is taken as a clean synchronous signal and is registered once before use.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `force_sleep` is high at a clock edge, `core_sleep` is high after that edge, whatever the state of `auto_sleep_en` and `line_energy`. Forced sleep has priority over the automatic mode.
- R2: When `force_sleep` goes low and `auto_sleep_en` is low, `core_sleep` is low after the next clock edge.
- R3: With `force_sleep` and `auto_sleep_en` both low at an edge, `core_sleep` is low after that edge.
- R4: With `auto_sleep_en` high and `force_sleep` low, a low `line_energy` sampled at edge k makes `core_sleep` high after edge k+1. The input is registered once, which gives the one-cycle latency.
- R5: In the automatic mode, a rise of `line_energy` sampled at edge k makes `core_sleep` low after edge k+1.
- R6: `tx_block` is high exactly in the cycles in which `core_sleep` is high.
- R7: `wake_pulse` is high for one cycle only. That cycle is the first cycle with `core_sleep` low after a cycle with `core_sleep` high, whatever the cause of the wake.
- R8: A wake caused by a registered rise of `line_energy` in the automatic mode, with `wake_irq_en` high at that edge, sets the flag. `irq_n` then goes low in the same cycle as `wake_pulse`.
- R9: No flag is set by a wake while `wake_irq_en` is low, or by a wake caused by clearing `force_sleep` while the energy level stays steady.
- R10: A high `irq_clear` at an edge clears the flag, and `irq_n` is high after it. If a set occurs at the same edge, the set wins.
- R11: During and right after reset, `core_sleep`, `tx_block` and `wake_pulse` are low and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| force_sleep | input | 1 | Forced sleep control bit |
| auto_sleep_en | input | 1 | Enables the energy-following sleep |
| line_energy | input | 1 | Line energy present, synchronous |
| wake_irq_en | input | 1 | Enables the energy-wake interrupt |
| irq_clear | input | 1 | Management read strobe that clears the flag |
| core_sleep | output | 1 | Core power-down |
| tx_block | output | 1 | Transmit inhibit |
| wake_pulse | output | 1 | One-cycle exit pulse for the reset block |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A stuck or wrongly updated sleep register shows up on `core_sleep` and `tx_block` one edge after the input that should have moved it. A lost or extra stage in the energy path shifts the automatic transitions by a cycle, and R4 and R5 catch that at the exact edge. A wrong edge memory shows up as a missing or spurious `irq_n` fall in the cycle of `wake_pulse`. A flag that fails to hold or to clear differs from the expected level one cycle after the strobe.

// File: rtl/pd_pkg.sv
package pd_pkg;
  // Sleep request from the control bits and the registered energy level.
  function automatic logic want_sleep(input logic force_bit, input logic auto_bit,
                                      input logic energy_now);
    return force_bit | (auto_bit & ~energy_now);
  endfunction

  // Next value of the sticky flag; a set beats a clear.
  function automatic logic flag_next(input logic set_ev, input logic clr_ev,
                                     input logic cur);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/pd_energy_edge.sv
module pd_energy_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_energy,
  output logic energy_lvl,
  output logic energy_rise
);
  logic energy_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      energy_lvl  <= 1'b0;
      energy_prev <= 1'b0;
    end else begin
      energy_lvl  <= line_energy;
      energy_prev <= energy_lvl;
    end
  end

  assign energy_rise = energy_lvl & ~energy_prev;
endmodule

// File: rtl/pd_power_fsm.sv
module pd_power_fsm
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic force_sleep,
  input  logic auto_sleep_en,
  input  logic energy_lvl,
  output logic asleep,
  output logic waking,
  output logic wake_pulse
);
  logic sleep_req;

  assign sleep_req = want_sleep(force_sleep, auto_sleep_en, energy_lvl);
  assign waking    = asleep & ~sleep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      asleep     <= sleep_req;
      wake_pulse <= waking;
    end
  end
endmodule

// File: rtl/pd_irq_flag.sv
module pd_irq_flag
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(set_ev, clr_ev, flag);
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic force_sleep,
  input  logic auto_sleep_en,
  input  logic line_energy,
  input  logic wake_irq_en,
  input  logic irq_clear,
  output logic core_sleep,
  output logic tx_block,
  output logic wake_pulse,
  output logic irq_n
);
  logic energy_lvl;
  logic energy_rise;
  logic waking;
  logic irq_set;
  logic irq_flag;

  pd_energy_edge u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_energy (line_energy),
    .energy_lvl  (energy_lvl),
    .energy_rise (energy_rise)
  );

  pd_power_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .force_sleep   (force_sleep),
    .auto_sleep_en (auto_sleep_en),
    .energy_lvl    (energy_lvl),
    .asleep        (core_sleep),
    .waking        (waking),
    .wake_pulse    (wake_pulse)
  );

  // Energy-caused wake: leaving sleep on a fresh registered rise in auto mode.
  assign irq_set = waking & energy_rise & auto_sleep_en & wake_irq_en;

  pd_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (irq_set),
    .clr_ev (irq_clear),
    .flag   (irq_flag)
  );

  assign tx_block = core_sleep;
  assign irq_n    = ~irq_flag;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic force_sleep,
  input logic auto_sleep_en,
  input logic wake_irq_en,
  input logic irq_clear,
  input logic irq_set,
  input logic core_sleep,
  input logic wake_pulse,
  input logic irq_n
);
  assert_force_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    force_sleep |=> core_sleep);

  assert_awake_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_sleep && !auto_sleep_en) |=> !core_sleep);

  assert_pulse_on_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!core_sleep && $past(core_sleep)));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_irq_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (wake_pulse && $past(wake_irq_en) && $past(auto_sleep_en)));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !irq_set) |=> irq_n);
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .force_sleep   (force_sleep),
  .auto_sleep_en (auto_sleep_en),
  .wake_irq_en   (wake_irq_en),
  .irq_clear     (irq_clear),
  .irq_set       (irq_set),
  .core_sleep    (core_sleep),
  .wake_pulse    (wake_pulse),
  .irq_n         (irq_n)
);

// File: tb/test_pwrdn_ctrl.sv
module test_pwrdn_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_sleep = 1'b0, auto_sleep_en = 1'b0, line_energy = 1'b0;
  logic wake_irq_en = 1'b0, irq_clear = 1'b0;
  logic core_sleep, tx_block, wake_pulse, irq_n;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl i_pwrdn_ctrl (
    .clk(clk), .rst_n(rst_n), .force_sleep(force_sleep), .auto_sleep_en(auto_sleep_en),
    .line_energy(line_energy), .wake_irq_en(wake_irq_en), .irq_clear(irq_clear),
    .core_sleep(core_sleep), .tx_block(tx_block), .wake_pulse(wake_pulse), .irq_n(irq_n)
  );

  // Reference model written from the requirements.
  logic m_seen = 1'b0, m_seen_old = 1'b0, m_down = 1'b0, m_pulse = 1'b0, m_flag = 1'b0;

  function automatic logic ref_down(logic f, logic a, logic seen);
    if (f) return 1'b1;           // R1 priority
    if (!a) return 1'b0;          // R2, R3
    return !seen;                 // R4, R5
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_seen = 0; m_seen_old = 0; m_down = 0; m_pulse = 0; m_flag = 0;
    end else begin
      logic nd, energy_wake;
      nd = ref_down(force_sleep, auto_sleep_en, m_seen);
      energy_wake = m_down && !nd && auto_sleep_en && m_seen && !m_seen_old && wake_irq_en;
      m_pulse = m_down && !nd;
      m_flag  = energy_wake ? 1'b1 : (irq_clear ? 1'b0 : m_flag);
      m_down  = nd;
      m_seen_old = m_seen;
      m_seen  = line_energy;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1/R2/R3/R4/R5 core_sleep", core_sleep, m_down);
    check("R6 tx_block", tx_block, m_down);
    check("R7 wake_pulse", wake_pulse, m_pulse);
    check("R8/R9/R10 irq_n", irq_n, !m_flag);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 core_sleep in reset", core_sleep, 1'b0);
    check("R11 tx_block in reset", tx_block, 1'b0);
    check("R11 wake_pulse in reset", wake_pulse, 1'b0);
    check("R11 irq_n in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    step();
    check("R11 core_sleep after reset", core_sleep, 1'b0);

    // R1: forced sleep wins even with energy present and auto mode on.
    line_energy = 1; auto_sleep_en = 1; force_sleep = 1; wake_irq_en = 1;
    step();
    check("R1 forced sleep", core_sleep, 1'b1);
    check("R6 tx blocked", tx_block, 1'b1);
    // R2/R9: clear force with auto off; steady energy gives no interrupt.
    auto_sleep_en = 0; force_sleep = 0;
    step();
    check("R2 wake after force clear", core_sleep, 1'b0);
    check("R7 pulse on force wake", wake_pulse, 1'b1);
    check("R9 no irq on force wake", irq_n, 1'b1);
    step();
    check("R7 pulse lasts one cycle", wake_pulse, 1'b0);
    // R4: automatic sleep with no energy.
    auto_sleep_en = 1; line_energy = 0;
    step();
    check("R4 one cycle of latency", core_sleep, 1'b0);
    step();
    check("R4 asleep without energy", core_sleep, 1'b1);
    // R5/R8: energy returns.
    line_energy = 1;
    step();
    check("R5 still asleep one edge on", core_sleep, 1'b1);
    step();
    check("R5 awake on energy", core_sleep, 1'b0);
    check("R7 pulse on energy wake", wake_pulse, 1'b1);
    check("R8 irq on energy wake", irq_n, 1'b0);
    step();
    check("R10 flag sticky", irq_n, 1'b0);
    irq_clear = 1;
    step();
    irq_clear = 0;
    check("R10 read clears flag", irq_n, 1'b1);

    // Constrained random phase checked against the model each cycle.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) force_sleep = ~force_sleep;
      if ($urandom_range(0, 19) == 0) auto_sleep_en = ~auto_sleep_en;
      if ($urandom_range(0, 3) == 0) line_energy = ~line_energy;
      wake_irq_en = ($urandom_range(0, 3) != 0);
      irq_clear   = ($urandom_range(0, 7) == 0);
      step();
      compare_all();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule